// File: doc/BRIEF.md
# Repeating Transfer Queue Controller

This block is a per-channel scheduler placed in front of a data mover. Software-side logic submits transfer descriptors into a small in-order queue. Each submission carries two flags: one asks for the transfer to repeat, and one asks for it to take over from a repeating transfer when that transfer ends. Submitted entries wait until an issue strobe marks them runnable. The controller then presents one active descriptor to the mover and raises a start pulse each time that descriptor begins or begins again. When the mover reports the end of a pass, the controller decides what runs next. It can take the next issued entry, run the current repeating transfer again, or go idle.

Every accepted submission receives a transaction number from a wrapping counter. Each finished pass produces a one-cycle completion pulse that carries the number and descriptor of the pass. Pause freezes the channel. Terminate-all discards the active transfer and every queued entry, and no completion is reported for them. A capability parameter removes repeat support, and repeat requests are then refused with an error flag.

Top module: `xq_channel`

## Requirements
- R1: A submission is accepted when sub_valid is high, the queue holds fewer than DEPTH entries, term_all is low and sub_err is low. Each accepted submission gets a transaction ID one greater than the previous accepted one. The first ID after reset is 0, and IDs wrap modulo 2^ID_W. Refused submissions consume no ID.
- R2: An accepted entry does not start until an issue strobe arrives. An issue marks the entries held in the queue at that clock edge as runnable. Entries submitted later wait for another issue.
- R3: Runnable entries run in submission order. When the channel is idle and not paused, the head runnable entry becomes active at the next clock edge. act_desc and act_id are updated at that edge and act_start is high for one cycle. When a non-repeating transfer ends, the next runnable entry loads at the same edge, or the channel goes idle if there is none.
- R4: A transfer ends when mover_done is sampled high while act_valid is high, the channel is not paused and term_all is low. In the following cycle cmpl_pulse is high for one cycle, and cmpl_id and cmpl_desc hold the values of the pass that ended.
- R5: A transfer submitted with the repeat flag is restarted at its end unless R6 replaces it. The restart keeps the same descriptor and ID, raises act_start again, and each pass produces its own completion with the same ID.
- R6: A repeating transfer is replaced at its end only if the head runnable entry has the load-at-end flag. Otherwise it keeps repeating, and the head entry stays queued.
- R7: The load-at-end flag has no effect on a transfer that follows a non-repeating one. Such a transfer loads at the end exactly as an entry without the flag would.
- R8: term_all clears the active transfer, the queue and the runnable marking at the next edge, so busy is low in the following cycle. A mover_done in the same cycle produces no completion, and a submission in the same cycle is refused with sub_busy.
- R9: pause stops the channel from the next edge: act_run goes low, no transfer starts, and mover_done is ignored. resume restores operation from the next edge. If pause and resume are both high, pause wins.
- R10: A submission made while DEPTH entries are queued is refused with sub_busy high in the same cycle. The queued entries and their order are left unchanged.
- R11: With REPEAT_EN = 0, a submission with the repeat flag raises sub_err in the same cycle, keeps sub_busy low, is not queued and consumes no ID.
- R12: busy is high exactly when a transfer is active or the queue is not empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sub_valid | input | 1 | Submission strobe |
| sub_desc | input | DESC_W | Descriptor being submitted |
| sub_repeat | input | 1 | Submission asks to repeat |
| sub_load_eot | input | 1 | Submission may replace a repeating transfer at its end |
| sub_busy | output | 1 | Submission refused: queue full or terminate in progress |
| sub_err | output | 1 | Submission refused: repeat not supported |
| issue | input | 1 | Marks all queued entries runnable |
| pause | input | 1 | Freeze channel |
| resume | input | 1 | Unfreeze channel |
| term_all | input | 1 | Abort active and queued transfers |
| mover_done | input | 1 | Data mover finished the current pass |
| act_valid | output | 1 | A transfer is active |
| act_run | output | 1 | Active and not paused; the mover may work |
| act_start | output | 1 | One-cycle pulse when the active transfer starts or restarts |
| act_desc | output | DESC_W | Active descriptor |
| act_id | output | ID_W | Active transaction ID |
| cmpl_pulse | output | 1 | One-cycle completion pulse |
| cmpl_id | output | ID_W | ID of the pass that completed |
| cmpl_desc | output | DESC_W | Descriptor of the pass that completed |
| busy | output | 1 | Channel holds any transfer |

## Verification
The properties assume that mover_done arrives only while a transfer is active and running, so a pause is never expected to swallow a genuine end of pass. They also assume that issue, pause, resume and term_all are single-cycle strobes. The stimulus drives mover_done only after it has seen act_valid, except for one deliberate strobe during a pause that checks the ignore rule. All strobes are held for exactly one clock. Submissions into a full queue or during a terminate are made on purpose, so the refusal paths are driven and no entry is ever lost by accident.

// File: rtl/xq_pkg.sv
package xq_pkg;

    // What the channel does with its active slot at the coming edge.
    typedef enum logic [1:0] {
        XQ_HOLD    = 2'd0,
        XQ_LOAD    = 2'd1,
        XQ_RESTART = 2'd2,
        XQ_STOP    = 2'd3
    } xq_next_e;

    // End-of-pass policy: repeating transfers yield only to a runnable
    // head entry that carries the load-at-end flag.
    function automatic xq_next_e xq_decide(
        input logic active,
        input logic ended,
        input logic rep,
        input logic head_ok,
        input logic head_eot,
        input logic paused
    );
        if (!active)  return (head_ok && !paused) ? XQ_LOAD : XQ_HOLD;
        if (!ended)   return XQ_HOLD;
        if (rep)      return (head_ok && head_eot) ? XQ_LOAD : XQ_RESTART;
        return head_ok ? XQ_LOAD : XQ_STOP;
    endfunction

endpackage

// File: rtl/xq_queue.sv
module xq_queue #(
    parameter int DEPTH = 4,
    parameter int W     = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             push,
    input  logic             pop,
    input  logic [W-1:0]     wdata,
    output logic [W-1:0]     rdata,
    output logic [CNT_W-1:0] count
);
    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push && !flush) mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            count <= count + CNT_W'(push) - CNT_W'(pop);
        end
    end

    assign rdata = mem[rd_ptr];
endmodule

// File: rtl/xq_idctr.sv
module xq_idctr #(
    parameter int ID_W = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            inc,
    output logic [ID_W-1:0] id
);
    always_ff @(posedge clk) begin
        if (rst)      id <= '0;
        else if (inc) id <= id + 1'b1;
    end
endmodule

// File: rtl/xq_channel.sv
module xq_channel
    import xq_pkg::*;
#(
    parameter int DESC_W    = 16,
    parameter int ID_W      = 4,
    parameter int DEPTH     = 4,
    parameter bit REPEAT_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sub_valid,
    input  logic [DESC_W-1:0] sub_desc,
    input  logic              sub_repeat,
    input  logic              sub_load_eot,
    output logic              sub_busy,
    output logic              sub_err,
    input  logic              issue,
    input  logic              pause,
    input  logic              resume,
    input  logic              term_all,
    input  logic              mover_done,
    output logic              act_valid,
    output logic              act_run,
    output logic              act_start,
    output logic [DESC_W-1:0] act_desc,
    output logic [ID_W-1:0]   act_id,
    output logic              cmpl_pulse,
    output logic [ID_W-1:0]   cmpl_id,
    output logic [DESC_W-1:0] cmpl_desc,
    output logic              busy
);
    localparam int CNT_W  = $clog2(DEPTH + 1);
    localparam int ENT_W  = DESC_W + ID_W + 2;
    localparam int EOT_B  = DESC_W;
    localparam int REP_B  = DESC_W + 1;
    localparam int ID_LSB = DESC_W + 2;

    logic [CNT_W-1:0]  q_count, issued_q;
    logic [ENT_W-1:0]  head_ent, push_ent;
    logic [ID_W-1:0]   next_id;
    logic              accept, pop, end_evt, head_ok, paused;
    logic              act_rep_q;
    xq_next_e          nxt;

    generate
        if (REPEAT_EN) begin : g_rep_on
            assign sub_err = 1'b0;
        end else begin : g_rep_off
            assign sub_err = sub_valid && sub_repeat;
        end
    endgenerate

    assign sub_busy = sub_valid && !sub_err && (term_all || q_count == CNT_W'(DEPTH));
    assign accept   = sub_valid && !sub_err && !sub_busy;
    assign push_ent = {next_id, sub_repeat, sub_load_eot, sub_desc};
    assign head_ok  = issued_q != '0;
    assign end_evt  = act_valid && mover_done && !paused && !term_all;
    assign nxt      = xq_decide(act_valid, end_evt, act_rep_q, head_ok, head_ent[EOT_B], paused);
    assign pop      = (nxt == XQ_LOAD) && !term_all;

    xq_queue #(.DEPTH(DEPTH), .W(ENT_W)) u_queue (
        .clk   (clk),
        .rst   (rst),
        .flush (term_all),
        .push  (accept),
        .pop   (pop),
        .wdata (push_ent),
        .rdata (head_ent),
        .count (q_count)
    );

    xq_idctr #(.ID_W(ID_W)) u_ids (
        .clk (clk),
        .rst (rst),
        .inc (accept),
        .id  (next_id)
    );

    // Runnable entries always sit at the head of the queue.
    always_ff @(posedge clk) begin
        if (rst || term_all) issued_q <= '0;
        else if (issue)      issued_q <= q_count - CNT_W'(pop);
        else                 issued_q <= issued_q - CNT_W'(pop);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            paused     <= 1'b0;
            act_valid  <= 1'b0;
            act_rep_q  <= 1'b0;
            act_desc   <= '0;
            act_id     <= '0;
            act_start  <= 1'b0;
            cmpl_pulse <= 1'b0;
            cmpl_id    <= '0;
            cmpl_desc  <= '0;
        end else begin
            act_start  <= 1'b0;
            cmpl_pulse <= 1'b0;
            if (pause)       paused <= 1'b1;
            else if (resume) paused <= 1'b0;
            if (term_all) begin
                act_valid <= 1'b0;
            end else begin
                case (nxt)
                    XQ_LOAD: begin
                        act_valid <= 1'b1;
                        act_rep_q <= head_ent[REP_B];
                        act_desc  <= head_ent[DESC_W-1:0];
                        act_id    <= head_ent[ID_LSB +: ID_W];
                        act_start <= 1'b1;
                    end
                    XQ_RESTART: act_start <= 1'b1;
                    XQ_STOP:    act_valid <= 1'b0;
                    default:    ;
                endcase
            end
            if (end_evt) begin
                cmpl_pulse <= 1'b1;
                cmpl_id    <= act_id;
                cmpl_desc  <= act_desc;
            end
        end
    end

    assign act_run = act_valid && !paused;
    assign busy    = act_valid || (q_count != '0);
endmodule

// File: rtl/xq_channel_chk.sv
module xq_channel_chk #(
    parameter int DEPTH = 4,
    parameter int CNT_W = 3,
    parameter int ID_W  = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             sub_valid,
    input logic             sub_repeat,
    input logic             sub_err,
    input logic             sub_busy,
    input logic             term_all,
    input logic             resume,
    input logic             mover_done,
    input logic             act_valid,
    input logic             act_run,
    input logic [ID_W-1:0]  act_id,
    input logic             cmpl_pulse,
    input logic             busy,
    input logic [CNT_W-1:0] q_count,
    input logic [CNT_W-1:0] issued_q
);
    AST_ERR_ONLY_ON_REPEAT: assert property (@(posedge clk) disable iff (rst)
        sub_err |-> (sub_valid && sub_repeat)); // R11

    AST_FULL_REFUSES: assert property (@(posedge clk) disable iff (rst)
        (sub_valid && !sub_err && q_count == CNT_W'(DEPTH)) |-> sub_busy); // R10

    AST_TERM_SILENCES: assert property (@(posedge clk) disable iff (rst)
        term_all |=> (!cmpl_pulse && !busy)); // R8

    AST_START_NEEDS_ISSUE: assert property (@(posedge clk) disable iff (rst)
        (!act_valid && issued_q == '0) |=> !act_valid); // R2

    AST_PAUSE_FREEZES: assert property (@(posedge clk) disable iff (rst)
        (act_valid && !act_run && !resume && !term_all) |=> (act_valid && $stable(act_id) && !cmpl_pulse)); // R9

    AST_CMPL_FROM_DONE: assert property (@(posedge clk) disable iff (rst)
        cmpl_pulse |-> ($past(mover_done) && $past(act_valid))); // R4
endmodule

bind xq_channel xq_channel_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W), .ID_W(ID_W)) u_chk (.*);

// File: tb/sim_xq_channel.sv
module sim_xq_channel;
    localparam int DW = 16;
    localparam int IW = 4;
    localparam int S_ISSUE = 0, S_PAUSE = 1, S_RESUME = 2, S_TERM = 3, S_DONE = 4, S_TERMDONE = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic          sub_valid = 0, sub_repeat = 0, sub_load_eot = 0;
    logic [DW-1:0] sub_desc = '0;
    logic          issue = 0, pause = 0, resume = 0, term_all = 0, mover_done = 0;
    logic          sub_busy, sub_err, act_valid, act_run, act_start, cmpl_pulse, busy;
    logic [DW-1:0] act_desc, cmpl_desc;
    logic [IW-1:0] act_id, cmpl_id;

    xq_channel #(.DESC_W(DW), .ID_W(IW), .DEPTH(4), .REPEAT_EN(1'b1)) u0 (
        .clk(clk), .rst(rst), .sub_valid(sub_valid), .sub_desc(sub_desc),
        .sub_repeat(sub_repeat), .sub_load_eot(sub_load_eot), .sub_busy(sub_busy),
        .sub_err(sub_err), .issue(issue), .pause(pause), .resume(resume),
        .term_all(term_all), .mover_done(mover_done), .act_valid(act_valid),
        .act_run(act_run), .act_start(act_start), .act_desc(act_desc), .act_id(act_id),
        .cmpl_pulse(cmpl_pulse), .cmpl_id(cmpl_id), .cmpl_desc(cmpl_desc), .busy(busy)
    );

    // Second channel without repeat capability.
    logic          v1 = 0, r1 = 0, issue1 = 0, done1 = 0;
    logic          sbusy1, err1, av1, run1, st1, cp1, bz1;
    logic [DW-1:0] ad1, cd1;
    logic [IW-1:0] aid1, cid1;

    xq_channel #(.DESC_W(DW), .ID_W(IW), .DEPTH(4), .REPEAT_EN(1'b0)) u1 (
        .clk(clk), .rst(rst), .sub_valid(v1), .sub_desc(16'h0C0C),
        .sub_repeat(r1), .sub_load_eot(1'b0), .sub_busy(sbusy1),
        .sub_err(err1), .issue(issue1), .pause(1'b0), .resume(1'b0),
        .term_all(1'b0), .mover_done(done1), .act_valid(av1),
        .act_run(run1), .act_start(st1), .act_desc(ad1), .act_id(aid1),
        .cmpl_pulse(cp1), .cmpl_id(cid1), .cmpl_desc(cd1), .busy(bz1)
    );

    int errs = 0;
    int checks = 0;
    typedef struct { int id; int desc; } exp_t;
    exp_t exq[$];

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic submit(input int d, input bit rep, input bit eot, output bit bsy, output bit err);
        @(negedge clk);
        sub_valid = 1; sub_desc = DW'(d); sub_repeat = rep; sub_load_eot = eot;
        #1;
        bsy = sub_busy; err = sub_err;
        @(posedge clk); #1;
        sub_valid = 0; sub_repeat = 0; sub_load_eot = 0;
    endtask

    task automatic sub_ok(input int d, input bit rep, input bit eot);
        bit b, e;
        submit(d, rep, eot, b, e);
        check("R1 accepted", int'(b | e), 0);
    endtask

    task automatic strobe(input int which);
        @(negedge clk);
        case (which)
            S_ISSUE:    issue = 1;
            S_PAUSE:    pause = 1;
            S_RESUME:   resume = 1;
            S_TERM:     term_all = 1;
            S_DONE:     mover_done = 1;
            S_TERMDONE: begin term_all = 1; mover_done = 1; end
            default:    ;
        endcase
        @(posedge clk); #1;
        issue = 0; pause = 0; resume = 0; term_all = 0; mover_done = 0;
    endtask

    task automatic expect_c(input int id, input int d);
        exq.push_back('{id, d});
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (!rst && cmpl_pulse) begin
            exp_t e;
            if (exq.size() == 0) begin
                checks++; errs++;
                $display("FAIL R4 unexpected completion actual id=%0d expected none", cmpl_id);
            end else begin
                e = exq.pop_front();
                check("R4 completion id", int'(cmpl_id), e.id);
                check("R4 completion desc", int'(cmpl_desc), e.desc);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        errs++; checks++;
        $display("FAIL R3 watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        bit b, e;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        check("R12 reset busy", int'(busy), 0);
        check("R3 reset act_valid", int'(act_valid), 0);
        check("R4 reset cmpl", int'(cmpl_pulse), 0);

        // Pending until issue, then in order
        sub_ok(16'h1111, 0, 0);
        sub_ok(16'h2222, 0, 0);
        tick(3);
        check("R2 no start before issue", int'(act_valid), 0);
        check("R12 busy with queued", int'(busy), 1);
        strobe(S_ISSUE); tick(1);
        check("R3 first desc", int'(act_desc), 16'h1111);
        check("R1 first id", int'(act_id), 0);
        sub_ok(16'h3c3c, 0, 0);
        expect_c(0, 16'h1111); strobe(S_DONE);
        check("R3 next desc", int'(act_desc), 16'h2222);
        check("R1 second id", int'(act_id), 1);
        check("R3 start pulse", int'(act_start), 1);
        expect_c(1, 16'h2222); strobe(S_DONE);
        check("R2 unissued waits", int'(act_valid), 0);
        tick(3);
        check("R2 still idle", int'(act_valid), 0);
        check("R12 busy queued", int'(busy), 1);
        strobe(S_ISSUE); tick(1);
        check("R1 third id", int'(act_id), 2);
        expect_c(2, 16'h3c3c); strobe(S_DONE);
        check("R12 idle busy", int'(busy), 0);

        // Repeat, no replacement without load-at-end
        sub_ok(16'h3333, 1, 0);
        strobe(S_ISSUE); tick(1);
        expect_c(3, 16'h3333); strobe(S_DONE);
        check("R5 restart pulse", int'(act_start), 1);
        check("R5 same id", int'(act_id), 3);
        check("R5 same desc", int'(act_desc), 16'h3333);
        sub_ok(16'h4444, 0, 0);
        strobe(S_ISSUE);
        expect_c(3, 16'h3333); strobe(S_DONE);
        check("R6 keeps repeating", int'(act_id), 3);
        sub_ok(16'h5555, 0, 1);
        strobe(S_ISSUE);
        expect_c(3, 16'h3333); strobe(S_DONE);
        check("R6 head without flag blocks", int'(act_id), 3);
        strobe(S_TERMDONE);
        check("R8 cleared", int'(busy), 0);
        check("R8 inactive", int'(act_valid), 0);
        tick(1);
        @(negedge clk);
        term_all = 1; sub_valid = 1; sub_desc = 16'hdead;
        #1 check("R8 submit refused", int'(sub_busy), 1);
        @(posedge clk); #1;
        term_all = 0; sub_valid = 0;
        check("R8 nothing stored", int'(busy), 0);

        // Repeat replaced by load-at-end entry
        sub_ok(16'h6666, 1, 0);
        strobe(S_ISSUE); tick(1);
        sub_ok(16'h7777, 0, 1);
        strobe(S_ISSUE);
        expect_c(6, 16'h6666); strobe(S_DONE);
        check("R6 replaced id", int'(act_id), 7);
        check("R6 replaced desc", int'(act_desc), 16'h7777);
        expect_c(7, 16'h7777); strobe(S_DONE);
        check("R6 replacement not repeating", int'(act_valid), 0);

        // Load-at-end after a plain transfer
        sub_ok(16'h8888, 0, 0);
        sub_ok(16'h9999, 0, 1);
        strobe(S_ISSUE); tick(1);
        expect_c(8, 16'h8888); strobe(S_DONE);
        check("R7 plain follow", int'(act_id), 9);
        expect_c(9, 16'h9999); strobe(S_DONE);
        check("R7 ends normally", int'(act_valid), 0);

        // Pause and resume
        strobe(S_PAUSE);
        sub_ok(16'haaaa, 0, 0);
        strobe(S_ISSUE); tick(3);
        check("R9 no start while paused", int'(act_valid), 0);
        strobe(S_RESUME); tick(1);
        check("R9 starts after resume", int'(act_run), 1);
        strobe(S_PAUSE);
        check("R9 run drops", int'(act_run), 0);
        strobe(S_DONE); tick(2);
        check("R9 done ignored", int'(act_id), 10);
        check("R9 still active", int'(act_valid), 1);
        strobe(S_RESUME);
        check("R9 run back", int'(act_run), 1);
        expect_c(10, 16'haaaa); strobe(S_DONE);

        // Full queue and ID wrap
        for (int i = 0; i < 4; i++) sub_ok(16'hb000 + i, 0, 0);
        submit(16'hbeef, 0, 0, b, e);
        check("R10 full refused", int'(b), 1);
        strobe(S_ISSUE); tick(1);
        for (int i = 0; i < 4; i++) begin
            expect_c(11 + i, 16'hb000 + i); strobe(S_DONE);
        end
        check("R10 drained", int'(act_valid), 0);
        sub_ok(16'hc001, 0, 0);
        sub_ok(16'hc002, 0, 0);
        strobe(S_ISSUE); tick(1);
        expect_c(15, 16'hc001); strobe(S_DONE);
        check("R1 id wraps", int'(act_id), 0);
        expect_c(0, 16'hc002); strobe(S_DONE);

        // Channel without repeat support
        @(negedge clk); v1 = 1; r1 = 1;
        #1 check("R11 err flag", int'(err1), 1);
        check("R11 not busy-refused", int'(sbusy1), 0);
        @(posedge clk); #1; v1 = 0; r1 = 0;
        check("R11 not queued", int'(bz1), 0);
        @(negedge clk); v1 = 1;
        @(posedge clk); #1; v1 = 0;
        @(negedge clk); issue1 = 1;
        @(posedge clk); #1; issue1 = 0;
        tick(1);
        @(negedge clk); done1 = 1;
        @(posedge clk); #1; done1 = 0;
        check("R11 completion", int'(cp1), 1);
        check("R11 no id consumed", int'(cid1), 0);

        tick(2);
        check("R4 all completions seen", exq.size(), 0);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule